// File: doc/BRIEF.md
# Host Parallel Sample Port

This block sits between a DSP host and the converter datapath of a line codec and carries 16-bit two's-complement samples both ways. The host writes a transmit word by pulsing an active-low write strobe, and the word is taken when the strobe rises. Each sample tick from the timing generator moves the most recent transmit word into the register that feeds the transmit datapath. On the same tick, the current receive sample from the datapath is latched into a read buffer.

The host reads the buffered receive word by pulling an active-low output-enable strobe. The port drives the bus once it sees that falling edge and stops driving once it sees the strobe rise. Both strobes count only while the active-low chip select is low.

The host strobes are asynchronous to the block. They are synchronized into the system clock domain, and their edges are detected there. Two control inputs change the data path. Digital loopback feeds the latched receive samples back into the transmit output. Read-back test mode makes host reads return the last captured transmit word.

Top module: `host_sample_port`

## Requirements
- R1: After reset, `tx_sample` is 0, `bus_drive` is 0 and `bus_out` is 0.
- R2: A rising edge of `wr_n` while `cs_n` is low captures `bus_in`. The captured word appears on `tx_sample` after the next `sample_tick`.
- R3: A rising edge of `wr_n` while `cs_n` is high captures nothing. The next tick presents the previously captured word.
- R4: Each `sample_tick` latches `rx_sample`. A host read returns the latched word on `bus_out`. The word on `bus_out` stays fixed for the whole read, even if a tick occurs during it.
- R5: `bus_drive` goes to 1 after a falling edge of `rd_n` with `cs_n` low. It goes to 0 after the next rising edge of `rd_n`. While `bus_drive` is 0, `bus_out` is 0.
- R6: A falling edge of `rd_n` while `cs_n` is high does not raise `bus_drive`.
- R7: While `loop_en` is 1, each tick loads `tx_sample` with the receive sample latched at the previous tick, giving one sample of latency. Host writes are still captured but are not presented.
- R8: While `readback_en` is 1, a host read returns the last captured transmit word instead of the receive sample.
- R9: `tx_sample` changes only on a `sample_tick`. A new write between ticks leaves it unchanged.
- R10: All 16 bits pass unaltered in both directions, bit 0 being the LSB and bit 15 the MSB. This covers 0x8000, 0x7FFF and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle sample-rate pulse from the timing generator |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, the word is taken on the rising edge |
| rd_n | input | 1 | Host output enable, active low |
| bus_in | input | 16 | Host data bus as seen by the port |
| bus_out | output | 16 | Data the port drives toward the host, zero while idle |
| bus_drive | output | 1 | Output-enable for the external bus drivers |
| loop_en | input | 1 | Digital loopback control bit |
| readback_en | input | 1 | Transmit read-back test control bit |
| rx_sample | input | 16 | Receive sample from the datapath |
| tx_sample | output | 16 | Transmit sample toward the datapath |

## Verification
The bench writes several words between two ticks and checks that `tx_sample` does not move early. A design that forwarded writes straight through would change the transmit output mid-sample. It starts a tick during an open read to catch a read buffer that follows the live latch instead of holding the word taken at read start. It strobes write and read with chip select high, which a design that ignored chip select would turn into a changed transmit word or a driven bus. In loopback it expects the receive word from the previous tick, not the current one, and so reports an off-by-one-sample path in either direction.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
   // Source selected for the host read buffer
   typedef enum logic {
      RD_FROM_RX = 1'b0,
      RD_FROM_TX = 1'b1
   } rd_src_e;

   // Which datapath input feeds the transmit output register
   typedef enum logic {
      TX_FROM_HOST = 1'b0,
      TX_FROM_LOOP = 1'b1
   } tx_src_e;
endpackage

// File: rtl/hsp_strobe_sync.sv
module hsp_strobe_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 3,
   parameter logic [W-1:0] IDLE_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_q,
   output logic [W-1:0] sync_prev
);
   localparam int LAST = STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsp_strobe_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hsp_strobe_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] chain [LAST+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= LAST; i++) chain[i] <= IDLE_VAL;
      end else begin
         chain[0] <= async_in;
         for (int i = 1; i <= LAST; i++) chain[i] <= chain[i-1];
      end
   end

   assign sync_q    = chain[LAST-1];
   assign sync_prev = chain[LAST];
endmodule

// File: rtl/hsp_tx_path.sv
module hsp_tx_path
   import hsp_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_pulse,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick,
   input  tx_src_e           tx_src,
   input  logic [DATA_W-1:0] loop_word,
   output logic [DATA_W-1:0] tx_hold,
   output logic [DATA_W-1:0] tx_sample
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hsp_tx_path: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] next_sample;

   always_comb begin
      next_sample = (tx_src == TX_FROM_LOOP) ? loop_word : tx_hold;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold <= '0;
      end else if (wr_pulse) begin
         tx_hold <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sample <= '0;
      end else if (tick) begin
         tx_sample <= next_sample;
      end
   end

   AST_TX_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(tx_sample)); // R9

   AST_LOOP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && tx_src == TX_FROM_LOOP) |=> (tx_sample == $past(loop_word))); // R7
endmodule

// File: rtl/hsp_rx_path.sv
module hsp_rx_path
   import hsp_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter bit SNAPSHOT_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DATA_W-1:0] rx_in,
   input  logic              rd_start,
   input  logic              rd_end,
   input  rd_src_e           rd_src,
   input  logic [DATA_W-1:0] tx_hold,
   output logic [DATA_W-1:0] rx_buf,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_drive
);
   logic [DATA_W-1:0] sel_word;

   always_comb begin
      sel_word = (rd_src == RD_FROM_TX) ? tx_hold : rx_buf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf <= '0;
      end else if (tick) begin
         rx_buf <= rx_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_drive <= 1'b0;
      end else if (rd_start) begin
         bus_drive <= 1'b1;
      end else if (rd_end) begin
         bus_drive <= 1'b0;
      end
   end

   generate
      if (SNAPSHOT_READ) begin : g_snapshot
         logic [DATA_W-1:0] rd_word;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_word <= '0;
            end else if (rd_start) begin
               rd_word <= sel_word;
            end
         end
         assign bus_out = bus_drive ? rd_word : '0;

         AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_drive && !rd_start) |=> (!bus_drive || $stable(bus_out))); // R4
      end else begin : g_live
         assign bus_out = bus_drive ? sel_word : '0;
      end
   endgenerate

   AST_DRIVE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> bus_drive); // R5

   AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && !rd_start) |=> (!bus_drive && bus_out == '0)); // R5
endmodule

// File: rtl/host_sample_port.sv
module host_sample_port
   import hsp_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int SYNC_STAGES   = 2,
   parameter bit SNAPSHOT_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_drive,
   input  logic              loop_en,
   input  logic              readback_en,
   input  logic [DATA_W-1:0] rx_sample,
   output logic [DATA_W-1:0] tx_sample
);
   localparam int NSTROBE = 3;
   localparam int IDX_CS  = 0;
   localparam int IDX_WR  = 1;
   localparam int IDX_RD  = 2;

   generate
      if (DATA_W != 16) begin : g_width_note
         $error("host_sample_port: the host bus is defined as 16 bits");
      end
   endgenerate

   logic [NSTROBE-1:0] strobe_q, strobe_prev;
   logic               cs_act, wr_rise, rd_fall, rd_rise;
   logic [DATA_W-1:0]  tx_hold_w, rx_buf_w;
   rd_src_e            rd_src;
   tx_src_e            tx_src;

   hsp_strobe_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (NSTROBE),
      .IDLE_VAL({NSTROBE{1'b1}})
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({rd_n, wr_n, cs_n}),
      .sync_q   (strobe_q),
      .sync_prev(strobe_prev)
   );

   always_comb begin
      cs_act  = ~strobe_q[IDX_CS];
      wr_rise = cs_act &  strobe_q[IDX_WR] & ~strobe_prev[IDX_WR];
      rd_fall = cs_act & ~strobe_q[IDX_RD] &  strobe_prev[IDX_RD];
      rd_rise =          strobe_q[IDX_RD] & ~strobe_prev[IDX_RD];
      rd_src  = readback_en ? RD_FROM_TX : RD_FROM_RX;
      tx_src  = loop_en ? TX_FROM_LOOP : TX_FROM_HOST;
   end

   hsp_tx_path #(.DATA_W(DATA_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_pulse (wr_rise),
      .wr_data  (bus_in),
      .tick     (sample_tick),
      .tx_src   (tx_src),
      .loop_word(rx_buf_w),
      .tx_hold  (tx_hold_w),
      .tx_sample(tx_sample)
   );

   hsp_rx_path #(.DATA_W(DATA_W), .SNAPSHOT_READ(SNAPSHOT_READ)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sample_tick),
      .rx_in    (rx_sample),
      .rd_start (rd_fall),
      .rd_end   (rd_rise),
      .rd_src   (rd_src),
      .tx_hold  (tx_hold_w),
      .rx_buf   (rx_buf_w),
      .bus_out  (bus_out),
      .bus_drive(bus_drive)
   );

   AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_hold_w) |-> !$past(strobe_q[IDX_CS])); // R3

   AST_READ_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_drive) |-> !$past(strobe_q[IDX_CS])); // R6
endmodule

// File: tb/host_sample_port_bench.sv
`timescale 1ns/1ps
module host_sample_port_bench;
   typedef struct {
      logic [15:0] word;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_tick = 1'b0;
   logic        cs_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        rd_n = 1'b1;
   logic [15:0] bus_in = '0;
   logic [15:0] bus_out;
   logic        bus_drive;
   logic        loop_en = 1'b0;
   logic        readback_en = 1'b0;
   logic [15:0] rx_sample = '0;
   logic [15:0] tx_sample;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   exp_t        exp_q[$];
   logic [15:0] tx_model = '0;
   logic [15:0] rx_model = '0;

   always #2.5 clk = ~clk;

   host_sample_port u_host_sample_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_tick(sample_tick),
      .cs_n       (cs_n),
      .wr_n       (wr_n),
      .rd_n       (rd_n),
      .bus_in     (bus_in),
      .bus_out    (bus_out),
      .bus_drive  (bus_drive),
      .loop_en    (loop_en),
      .readback_en(readback_en),
      .rx_sample  (rx_sample),
      .tx_sample  (tx_sample)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Driver: one tick; the expected transmit word is queued for the monitor
   task automatic do_tick(input logic [15:0] rx_val, input string req);
      exp_t e;
      @(negedge clk);
      e.word = loop_en ? rx_model : tx_model;
      e.req  = req;
      exp_q.push_back(e);
      rx_model    = rx_val;
      rx_sample   = rx_val;
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
   endtask

   task automatic host_write(input logic [15:0] w, input bit selected);
      @(negedge clk);
      cs_n   = ~selected;
      bus_in = w;
      wr_n   = 1'b0;
      wait_neg(4);
      wr_n = 1'b1;
      wait_neg(5);
      bus_in = 16'hDEAD;
      cs_n   = 1'b1;
      if (selected) tx_model = w;
   endtask

   task automatic read_open();
      @(negedge clk);
      cs_n = 1'b0;
      rd_n = 1'b0;
      wait_neg(5);
   endtask

   task automatic read_close(input string req);
      rd_n = 1'b1;
      wait_neg(5);
      cs_n = 1'b1;
      check(bus_drive == 1'b0 && bus_out == 16'h0, req, bus_out, 16'h0);
   endtask

   task automatic host_read(input string req);
      logic [15:0] exp;
      exp = readback_en ? tx_model : rx_model;
      read_open();
      check(bus_drive == 1'b1, "R5 drive on", {15'h0, bus_drive}, 16'h1);
      check(bus_out == exp, req, bus_out, exp);
      read_close("R5 release");
   endtask

   // Monitor: compares tx_sample one step after each tick edge
   initial begin
      forever begin
         @(posedge clk);
         if (sample_tick) begin
            #1;
            if (exp_q.size() == 0) begin
               check(1'b0, "scoreboard empty", tx_sample, 16'h0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(tx_sample == e.word, e.req, tx_sample, e.word);
            end
         end
      end
   end

   initial begin
      #(1_000_000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual 0x0000 expected 0x0001");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(2);
      // R1 reset state
      check(tx_sample == 16'h0, "R1 tx_sample", tx_sample, 16'h0);
      check(bus_drive == 1'b0, "R1 bus_drive", {15'h0, bus_drive}, 16'h0);
      check(bus_out == 16'h0, "R1 bus_out", bus_out, 16'h0);

      // R2 basic write then tick
      host_write(16'h1234, 1'b1);
      do_tick(16'h0000, "R2 write presented");

      // R10 full-width words
      host_write(16'h8000, 1'b1);
      do_tick(16'h0000, "R10 0x8000");
      host_write(16'h7FFF, 1'b1);
      do_tick(16'h0000, "R10 0x7FFF");

      // R3 deselected write ignored
      host_write(16'hAAAA, 1'b0);
      do_tick(16'h0000, "R3 deselected write");

      // R9 no change between ticks
      host_write(16'h5555, 1'b1);
      host_write(16'h3C3C, 1'b1);
      check(tx_sample == 16'h7FFF, "R9 held between ticks", tx_sample, 16'h7FFF);
      do_tick(16'hFFFF, "R9 last write on tick");

      // R4 / R10 read of latched receive word
      host_read("R4 read rx 0xFFFF");

      // R4 snapshot held through a tick during the read
      read_open();
      check(bus_out == 16'hFFFF, "R4 read start", bus_out, 16'hFFFF);
      do_tick(16'h0123, "R4 tick during read");
      wait_neg(2);
      check(bus_out == 16'hFFFF, "R4 held during read", bus_out, 16'hFFFF);
      read_close("R5 release after read");
      host_read("R4 new rx word");

      // R6 deselected read
      @(negedge clk);
      cs_n = 1'b1;
      rd_n = 1'b0;
      wait_neg(6);
      check(bus_drive == 1'b0, "R6 deselected read", {15'h0, bus_drive}, 16'h0);
      check(bus_out == 16'h0, "R6 bus idle", bus_out, 16'h0);
      rd_n = 1'b1;
      wait_neg(5);

      // R8 read-back test mode
      readback_en = 1'b1;
      host_read("R8 readback tx word");
      readback_en = 1'b0;
      host_read("R8 off returns rx");

      // R7 digital loopback with one sample latency
      loop_en = 1'b1;
      do_tick(16'h0F0F, "R7 loop first");
      host_write(16'h6666, 1'b1);
      do_tick(16'hF0F0, "R7 loop second");
      do_tick(16'h0001, "R7 loop third");
      loop_en = 1'b0;
      do_tick(16'h0002, "R7 loop off");

      wait_neg(4);
      check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end
endmodule